// File: doc/BRIEF.md
# Banked Edge-Capture Interrupt Unit

This block watches a set of general-purpose input lines, grouped into byte-wide banks (three banks of eight by default). It records a selected edge on each line as a sticky pending bit and raises a single interrupt request while any bit is pending. Software reaches it through a 16-byte window with a byte-wide register interface. A page register at offset 7 decides what the per-bank registers at offsets 8, 9 and 10 mean: the enable mask, the edge-polarity mask, or the latched pending (identification) bits. A summary register at offset 6 shows which banks hold pending events.

Every line passes through a two-flop synchronizer before edge detection. A line captures an edge only while its enable bit is set. Software acknowledges an event by writing its enable bit to 0, which clears the pending bit, and then writing it back to 1. Offsets 0 to 5 belong to plain data ports that live outside this block, so here they read as zero.

Top module: `ecap_irq_unit`

## Requirements
- R1: After reset the enable masks, polarity masks, pending bits and page register are all zero, and `irq` is low.
- R2: A read of offset 7 returns the last byte written to offset 7.
- R3: When the page register holds 0x80, offset 8+n reads and writes the enable mask of bank n, with bit k belonging to line 8n+k.
- R4: When the page register holds 0x40, offset 8+n reads and writes the polarity mask of bank n. A bit value of 1 means the line detects rising edges, and 0 means it detects falling edges.
- R5: An enabled line with polarity 1 latches its pending bit on a rising edge of its synchronized input and ignores falling edges.
- R6: An enabled line with polarity 0 latches its pending bit on a falling edge and ignores rising edges.
- R7: An edge on a line whose enable bit is 0 sets no pending bit.
- R8: When the page register holds 0xC0, offset 8+n reads the pending bits of bank n. Pending bits stay set until they are cleared, and writes to offsets 8 to 10 under this page have no effect.
- R9: Offset 6 reads bank n's any-pending flag in bit n (bits 2..0), and bits 7..3 read as 0.
- R10: Writing a 0 to an enable bit clears that line's pending bit. Writing 0 and then 1 acknowledges the event and re-arms the line.
- R11: If a qualifying edge and a clearing enable write fall in the same cycle, the pending bit stays set.
- R12: `irq` is high exactly while at least one pending bit is set.
- R13: Offsets 0 to 5 and 11 to 15 read as 0. When the page register holds any value other than 0x80, 0x40 or 0xC0, offsets 8 to 10 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| line_in | input | 24 | Asynchronous input lines, bank n on bits 8n+7..8n |
| irq | output | 1 | Interrupt request, high while any event is pending |

## Verification
The hardest case to reach from the ports is a new edge landing in the exact cycle that a clearing enable write takes effect. Pins are sampled by two synchronizer flops and an edge-history flop, so the bench changes a pin and then starts the clearing write two clock edges later. That way the write strobe is sampled on the same edge where the detector would latch the event. A second line in the same bank already holds a pending bit, so a single read shows both effects: the old bit is cleared and the new one survives. The bench also checks that edges of the wrong polarity and edges on masked lines leave the identification register unchanged.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

   // fixed byte offsets inside the 16-byte window
   localparam logic [3:0] OFS_SUMMARY = 4'd6;
   localparam logic [3:0] OFS_PAGE    = 4'd7;
   localparam logic [3:0] OFS_BANK0   = 4'd8;

   // page register codes
   localparam logic [7:0] PAGE_CODE_EN  = 8'h80;
   localparam logic [7:0] PAGE_CODE_POL = 8'h40;
   localparam logic [7:0] PAGE_CODE_ID  = 8'hC0;

   typedef enum logic [1:0] {
      PG_NONE,
      PG_ENABLE,
      PG_POLARITY,
      PG_IDENT
   } page_fn_e;

   function automatic page_fn_e decode_page(input logic [7:0] code);
      page_fn_e fn;
      case (code)
         PAGE_CODE_EN:  fn = PG_ENABLE;
         PAGE_CODE_POL: fn = PG_POLARITY;
         PAGE_CODE_ID:  fn = PG_IDENT;
         default:       fn = PG_NONE;
      endcase
      return fn;
   endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
   parameter int WIDTH  = 24,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ecap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/ecap_bank.sv
module ecap_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_in,
   input  logic             en_we,
   input  logic             pol_we,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] en_q,
   output logic [WIDTH-1:0] pol_q,
   output logic [WIDTH-1:0] pend_q
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] fall;
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] clr;

   assign rise = sync_in & ~prev_q;
   assign fall = ~sync_in & prev_q;
   // enable is sampled in the cycle the edge is seen
   assign hit  = en_q & ((pol_q & rise) | (~pol_q & fall));
   // a zero written into the enable mask drops the matching pending bit
   assign clr  = en_we ? ~wr_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         en_q   <= '0;
         pol_q  <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= sync_in;
         if (en_we) begin
            en_q <= wr_data;
         end
         if (pol_we) begin
            pol_q <= wr_data;
         end
         // a fresh edge beats a simultaneous clear
         pend_q <= hit | (pend_q & ~clr);
      end
   end

endmodule

// File: rtl/ecap_regmap.sv
module ecap_regmap
   import ecap_pkg::*;
#(
   parameter int NB = 3,
   parameter int W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [3:0]          addr,
   input  logic                wr,
   input  logic [7:0]          wdata,
   input  logic [NB-1:0][W-1:0] en_q,
   input  logic [NB-1:0][W-1:0] pol_q,
   input  logic [NB-1:0][W-1:0] pend_q,
   output logic [NB-1:0]       en_we,
   output logic [NB-1:0]       pol_we,
   output logic [7:0]          rdata,
   output logic [7:0]          page_q
);

   if (W != 8) begin : g_bad_width
      $error("ecap_regmap: bank width must match the byte bus");
   end
   if (NB < 1 || NB > 8) begin : g_bad_banks
      $error("ecap_regmap: bank count must be 1..8 to fit the window");
   end

   page_fn_e      page_fn;
   logic [NB-1:0] sel;
   logic [NB-1:0] summary;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (wr && addr == OFS_PAGE) begin
         page_q <= wdata;
      end
   end

   assign page_fn = decode_page(page_q);

   always_comb begin
      for (int b = 0; b < NB; b++) begin
         sel[b]     = (addr == 4'(OFS_BANK0 + 4'(b)));
         en_we[b]   = wr && sel[b] && (page_fn == PG_ENABLE);
         pol_we[b]  = wr && sel[b] && (page_fn == PG_POLARITY);
         summary[b] = |pend_q[b];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == OFS_SUMMARY) begin
         rdata[NB-1:0] = summary;
      end else if (addr == OFS_PAGE) begin
         rdata = page_q;
      end else begin
         for (int b = 0; b < NB; b++) begin
            if (sel[b]) begin
               case (page_fn)
                  PG_ENABLE:   rdata = en_q[b];
                  PG_POLARITY: rdata = pol_q[b];
                  PG_IDENT:    rdata = pend_q[b];
                  default:     rdata = '0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/ecap_irq_unit.sv
module ecap_irq_unit #(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [3:0]                  bus_addr,
   input  logic                        bus_wr,
   input  logic [7:0]                  bus_wdata,
   output logic [7:0]                  bus_rdata,
   input  logic [NUM_BANKS*BANK_W-1:0] line_in,
   output logic                        irq
);

   localparam int LINES = NUM_BANKS * BANK_W;

   logic [LINES-1:0]                  line_sync;
   logic [NUM_BANKS-1:0][BANK_W-1:0]  en_all;
   logic [NUM_BANKS-1:0][BANK_W-1:0]  pol_all;
   logic [NUM_BANKS-1:0][BANK_W-1:0]  pend_all;
   logic [NUM_BANKS-1:0]              en_we;
   logic [NUM_BANKS-1:0]              pol_we;
   logic [7:0]                        page_cur;

   ecap_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (line_in),
      .sync_out (line_sync)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ecap_bank #(
         .WIDTH (BANK_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_in (line_sync[b*BANK_W +: BANK_W]),
         .en_we   (en_we[b]),
         .pol_we  (pol_we[b]),
         .wr_data (bus_wdata[BANK_W-1:0]),
         .en_q    (en_all[b]),
         .pol_q   (pol_all[b]),
         .pend_q  (pend_all[b])
      );
   end

   ecap_regmap #(
      .NB (NUM_BANKS),
      .W  (BANK_W)
   ) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wr     (bus_wr),
      .wdata  (bus_wdata),
      .en_q   (en_all),
      .pol_q  (pol_all),
      .pend_q (pend_all),
      .en_we  (en_we),
      .pol_we (pol_we),
      .rdata  (bus_rdata),
      .page_q (page_cur)
   );

   assign irq = |pend_all;

endmodule

// File: rtl/ecap_irq_unit_chk.sv
module ecap_irq_unit_chk #(
   parameter int NB = 3,
   parameter int W  = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    bus_addr,
   input logic          bus_wr,
   input logic [7:0]    bus_wdata,
   input logic [7:0]    bus_rdata,
   input logic          irq,
   input logic [NB*W-1:0] pend_all,
   input logic [NB*W-1:0] en_all,
   input logic [7:0]    page_cur
);

   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend_all == '0 && en_all == '0 && page_cur == 8'h00 && !irq));

   // R2
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'd7) |=> (page_cur == $past(bus_wdata)));

   // R7
   no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_all & ~$past(pend_all) & ~$past(en_all)) == '0));

   // R8
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(pend_all) & ~pend_all) != '0) |-> $past(bus_wr)));

   // R9
   summary_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 4'd6) |-> (bus_rdata[7:NB] == '0));

   // R12
   irq_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 4'd6) |-> (irq == (bus_rdata[NB-1:0] != '0)));

endmodule

bind ecap_irq_unit ecap_irq_unit_chk #(
   .NB (NUM_BANKS),
   .W  (BANK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .pend_all  (pend_all),
   .en_all    (en_all),
   .page_cur  (page_cur)
);

// File: tb/ecap_irq_unit_tb.sv
module ecap_irq_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0;
   logic [7:0]  wdata = '0;
   logic [23:0] pins = '0;
   logic [7:0]  rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [7:0] exp_data;
      logic       exp_irq;
      string      tag;
   } sb_item_t;

   sb_item_t sb_q[$];

   always #5 clk = ~clk;

   ecap_irq_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .line_in   (pins),
      .irq       (irq)
   );

   // monitor: compare outputs at the falling edge against queued expectations
   always @(negedge clk) begin
      if (sb_q.size() != 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         checks++;
         if (rdata !== it.exp_data || irq !== it.exp_irq) begin
            fails++;
            $display("FAIL %s: rdata=%02h irq=%b expected rdata=%02h irq=%b",
                     it.tag, rdata, irq, it.exp_data, it.exp_irq);
         end
      end
   end

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic probe(input logic [3:0] a, input logic [7:0] exp_d,
                        input logic exp_i, input string tag);
      sb_item_t it;
      @(posedge clk); #1;
      addr = a;
      it.exp_data = exp_d; it.exp_irq = exp_i; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk); #1;
   endtask

   // change one bank's pins and wait until the edge has passed the detector
   task automatic drive_bank(input int b, input logic [7:0] v);
      @(posedge clk); #1;
      pins[b*8 +: 8] = v;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic summary_line();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: all requirements, actual=hung expected=finished");
         summary_line();
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      probe(4'd7, 8'h00, 1'b0, "R1 page after reset");
      probe(4'd6, 8'h00, 1'b0, "R1 summary after reset");
      bus_write(4'd7, 8'h80);
      probe(4'd8, 8'h00, 1'b0, "R1 enable bank0 after reset");
      probe(4'd10, 8'h00, 1'b0, "R1 enable bank2 after reset");
      bus_write(4'd7, 8'h40);
      probe(4'd9, 8'h00, 1'b0, "R1 polarity bank1 after reset");

      // R2 page read-back
      bus_write(4'd7, 8'h5A);
      probe(4'd7, 8'h5A, 1'b0, "R2 page read-back");

      // R13 unmapped page and offsets
      probe(4'd8, 8'h00, 1'b0, "R13 bank reg under unknown page");
      bus_write(4'd8, 8'hFF);
      probe(4'd0, 8'h00, 1'b0, "R13 offset 0");
      probe(4'd5, 8'h00, 1'b0, "R13 offset 5");
      probe(4'd11, 8'h00, 1'b0, "R13 offset 11");
      probe(4'd15, 8'h00, 1'b0, "R13 offset 15");
      bus_write(4'd7, 8'h80);
      probe(4'd8, 8'h00, 1'b0, "R13 write under unknown page ignored");

      // R3 enable page
      bus_write(4'd8, 8'h0F);
      bus_write(4'd9, 8'hF0);
      bus_write(4'd10, 8'h81);
      probe(4'd8, 8'h0F, 1'b0, "R3 enable bank0");
      probe(4'd9, 8'hF0, 1'b0, "R3 enable bank1");
      probe(4'd10, 8'h81, 1'b0, "R3 enable bank2");

      // R4 polarity page
      bus_write(4'd7, 8'h40);
      bus_write(4'd8, 8'hFF);
      bus_write(4'd9, 8'h00);
      bus_write(4'd10, 8'h01);
      probe(4'd8, 8'hFF, 1'b0, "R4 polarity bank0");
      probe(4'd10, 8'h01, 1'b0, "R4 polarity bank2");

      // R5 rising capture on bank0
      bus_write(4'd7, 8'hC0);
      drive_bank(0, 8'hFF);
      probe(4'd8, 8'h0F, 1'b1, "R5 rising edges latched");
      probe(4'd6, 8'h01, 1'b1, "R9 summary bank0");

      // R10 acknowledge
      bus_write(4'd7, 8'h80);
      bus_write(4'd8, 8'h00);
      bus_write(4'd7, 8'hC0);
      probe(4'd8, 8'h00, 1'b0, "R10 clear by enable zero");
      probe(4'd6, 8'h00, 1'b0, "R12 irq low when nothing pending");
      bus_write(4'd7, 8'h80);
      bus_write(4'd8, 8'h0F);

      // R5 falling ignored under rising polarity
      drive_bank(0, 8'h00);
      bus_write(4'd7, 8'hC0);
      probe(4'd8, 8'h00, 1'b0, "R5 falling edge ignored");

      // R6 falling capture on bank1, R7 masked lines
      drive_bank(1, 8'hFF);
      probe(4'd9, 8'h00, 1'b0, "R6 rising edge ignored");
      drive_bank(1, 8'h00);
      probe(4'd9, 8'hF0, 1'b1, "R6 falling edges latched, R7 masked low nibble");
      probe(4'd6, 8'h02, 1'b1, "R9 summary bank1");

      // R8 writes under ID page ignored
      bus_write(4'd9, 8'h00);
      probe(4'd9, 8'hF0, 1'b1, "R8 id write ignored");
      bus_write(4'd7, 8'h80);
      probe(4'd9, 8'hF0, 1'b1, "R8 enable untouched by id write");

      // R7 bank2 masked lines, mixed polarity
      drive_bank(2, 8'h7E);
      bus_write(4'd7, 8'hC0);
      probe(4'd10, 8'h00, 1'b1, "R7 edges on disabled lines");
      drive_bank(2, 8'h7F);
      probe(4'd10, 8'h01, 1'b1, "R5 bank2 bit0 rising");
      probe(4'd6, 8'h06, 1'b1, "R9 summary two banks");
      drive_bank(2, 8'hFF);
      probe(4'd10, 8'h01, 1'b1, "R6 bank2 bit7 rise ignored");
      drive_bank(2, 8'h7F);
      probe(4'd10, 8'h81, 1'b1, "R6 bank2 bit7 falling");

      // R10 full acknowledge of banks 1 and 2
      bus_write(4'd7, 8'h80);
      bus_write(4'd9, 8'h00);
      bus_write(4'd9, 8'hF0);
      bus_write(4'd10, 8'h00);
      bus_write(4'd10, 8'h81);
      bus_write(4'd7, 8'hC0);
      probe(4'd6, 8'h00, 1'b0, "R10 acknowledge sequence");
      probe(4'd9, 8'h00, 1'b0, "R10 bank1 id cleared");

      // R11 edge coincides with clearing write
      bus_write(4'd7, 8'h80);
      drive_bank(0, 8'h02);
      @(posedge clk); #1;
      pins[7:0] = 8'h03;
      @(posedge clk);
      @(posedge clk); #1;
      addr = 4'd8; wdata = 8'h00; wr = 1'b1;
      @(posedge clk); #1;
      wr = 1'b0;
      bus_write(4'd7, 8'hC0);
      probe(4'd8, 8'h01, 1'b1, "R11 new edge survives clear, old bit dropped");
      probe(4'd6, 8'h01, 1'b1, "R12 irq high with one pending bit");
      bus_write(4'd7, 8'h80);
      probe(4'd8, 8'h00, 1'b1, "R10 enable reads zero after clear");
      bus_write(4'd8, 8'h00);
      bus_write(4'd7, 8'hC0);
      probe(4'd6, 8'h00, 1'b0, "R12 irq drops after last clear");

      @(posedge clk); #1;
      done = 1'b1;
      summary_line();
      $finish;
   end

endmodule